// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block sits between an on-chip valid/ready request bus and an external asynchronous static RAM with a 17-bit address, a byte-wide data bus and active-low select, output-enable and write-enable strobes. A single request carries a direction bit, an address and, for writes, a data byte. The controller drives the RAM pins through a fixed sequence for each access and returns read data with a one-cycle valid pulse.

The RAM has no clock, so the timing it needs is expressed as whole cycles of the controller clock. Parameters give the clock period and the RAM's timing values in nanoseconds. Each value is turned into a cycle count at elaboration: the time is divided by the period, rounded up, and never allowed below one cycle. All pin outputs come from registers. The data bus is split into an output value, a driver enable and an input value, so the pad ring can build the tristate buffer. Between requests the RAM is deselected, which keeps it in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle (ready high), mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: An accepted read holds mem_cs_n=0, mem_oe_n=0, mem_we_n=1 for RD_CYC cycles, where RD_CYC is the largest of the rounded-up read-cycle, address-access and output-enable-access counts. The controller samples mem_dq_in on the edge that ends this window. rsp_valid is 1 for exactly one cycle, RD_CYC cycles after the accepting edge, together with the sampled byte on rsp_rdata.
- R3: An accepted write holds mem_cs_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1 for WR_CYC cycles, with mem_addr and mem_dq_out stable. WR_CYC is the largest of the rounded-up write-pulse, select-to-end, data-setup and write-cycle counts.
- R4: The data driver stays on for exactly one cycle after the write strobes return high, then turns off.
- R5: After a read, the controller waits TA_CYC cycles (the rounded-up output-to-high-Z time) with all strobes high before it accepts the next request. The data driver is never on while output enable is low.
- R6: req_ready is low from the accepting edge until the access ends: RD_CYC+TA_CYC cycles for a read and WR_CYC+1 cycles for a write.
- R7: A byte written to an address is returned by a later read of that address, including when the write follows a read back to back.
- R8: Output enable and write enable are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Value for the data pins when driven |
| mem_dq_oe | output | 1 | Data pin driver enable |
| mem_dq_in | input | DATA_W | Value seen on the data pins |

## Verification
The hardest case to reach is a write that arrives straight after a read, while the RAM may still be driving the bus after output enable rises. To create it, the bench keeps req_valid asserted so that a write is taken on the first ready cycle after a read. Its RAM model keeps driving for the turnaround window and treats any overlap with the controller's driver as a failure. The model also returns a wrong byte until the access count has passed, so any early sampling shows up as bad read data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WHOLD = 3'd4
  } seq_state_t;

  // whole cycles covering t_ns, at least one
  function automatic int unsigned cycles_for(input int unsigned t_ns,
                                             input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned TA_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             rsp_valid
);

  seq_state_t state_q, state_d;
  logic cs_d, oe_d, we_d, dq_oe_d;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    cs_d     = cs_n;
    oe_d     = oe_n;
    we_d     = we_n;
    dq_oe_d  = dq_oe;
    accept   = 1'b0;
    capture  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          cs_d     = 1'b0;
          if (req_write) begin
            state_d = ST_WRITE;
            cnt_val = CNT_W'(WR_CYC - 1);
            we_d    = 1'b0;
            dq_oe_d = 1'b1;
          end else begin
            state_d = ST_READ;
            cnt_val = CNT_W'(RD_CYC - 1);
            oe_d    = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          capture  = 1'b1;
          cs_d     = 1'b1;
          oe_d     = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(TA_CYC - 1);
          state_d  = ST_TURN;
        end
      end
      ST_TURN: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        if (cnt_zero) begin
          cs_d    = 1'b1;
          we_d    = 1'b1;
          state_d = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        dq_oe_d = 1'b0;
        state_d = ST_IDLE;
      end
      default: begin
        cs_d    = 1'b1;
        oe_d    = 1'b1;
        we_d    = 1'b1;
        dq_oe_d = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      cs_n      <= cs_d;
      oe_n      <= oe_d;
      we_n      <= we_d;
      dq_oe     <= dq_oe_d;
      rsp_valid <= capture;
    end
  end

endmodule

// File: rtl/asram_io.sv
module asram_io #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 20,
  parameter int unsigned T_AA_NS = 20,
  parameter int unsigned T_OE_NS = 8,
  parameter int unsigned T_WC_NS = 20,
  parameter int unsigned T_WP_NS = 15,
  parameter int unsigned T_CW_NS = 15,
  parameter int unsigned T_DW_NS = 10,
  parameter int unsigned T_HZ_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC = umax(umax(cycles_for(T_RC_NS, CLK_NS),
                                             cycles_for(T_AA_NS, CLK_NS)),
                                        cycles_for(T_OE_NS, CLK_NS));
  localparam int unsigned WR_CYC = umax(umax(cycles_for(T_WP_NS, CLK_NS),
                                             cycles_for(T_CW_NS, CLK_NS)),
                                        umax(cycles_for(T_DW_NS, CLK_NS),
                                             cycles_for(T_WC_NS, CLK_NS)));
  localparam int unsigned TA_CYC  = cycles_for(T_HZ_NS, CLK_NS);
  localparam int unsigned CNT_MAX = umax(umax(RD_CYC, WR_CYC), TA_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic             accept, capture, cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  asram_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_zero  (cnt_zero),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .rsp_valid (rsp_valid)
  );

  asram_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out
);

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_at_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $rose(mem_oe_n));

  assert_write_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

  assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_driver_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $fell(mem_we_n));

  assert_driver_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

  assert_no_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_oe_we_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;

  localparam int CLK_NS = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int T_RC = 20, T_AA = 20, T_OE = 8;
  localparam int T_WC = 20, T_WP = 35, T_CW = 15, T_DW = 10, T_HZ = 25;

  function automatic int cdiv(input int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int fmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_E = fmax(fmax(cdiv(T_RC), cdiv(T_AA)), cdiv(T_OE));
  localparam int WR_E = fmax(fmax(cdiv(T_WP), cdiv(T_CW)), fmax(cdiv(T_DW), cdiv(T_WC)));
  localparam int TA_E = cdiv(T_HZ);
  localparam int AA_E = cdiv(T_AA);

  logic              clk, rst_n;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] mem_dq_out, mem_dq_in;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  asram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
    .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_OE_NS(T_OE),
    .T_WC_NS(T_WC), .T_WP_NS(T_WP), .T_CW_NS(T_CW),
    .T_DW_NS(T_DW), .T_HZ_NS(T_HZ)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + ((a >> 5) * 7) + 3);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // RAM model: drives late data, keeps driving through the high-Z window
  logic [7:0]        mem [DEPTH];
  int                low_cnt = 0, hold = 0, wlen = 0;
  bit                whold = 0;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdat;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    mem_dq_in = 8'hEE;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;
      automatic bit wr_act = !mem_cs_n && !mem_we_n;
      if (mem_dq_oe && (rd_act || hold > 0))
        chk(0, "R5 driver overlaps RAM output", hold, 0);
      if (rd_act) begin
        low_cnt++;
        hold = TA_E;
        mem_dq_in = (low_cnt >= AA_E) ? mem[mem_addr] : 8'hEE;
      end else begin
        if (low_cnt > 0) chk(low_cnt == RD_E, "R2 read strobe length", low_cnt, RD_E);
        low_cnt = 0;
        if (hold > 0) hold--;
        mem_dq_in = 8'hEE;
      end
      if (whold) begin
        chk(!mem_dq_oe, "R4 driver off after hold", mem_dq_oe, 0);
        whold = 0;
      end
      if (wr_act) begin
        if (!mem_dq_oe || !mem_oe_n) chk(0, "R3 write pins", mem_dq_oe, 1);
        if (wlen > 0 && (mem_addr != waddr || mem_dq_out != wdat))
          chk(0, "R3 address/data stable", mem_dq_out, wdat);
        waddr = mem_addr;
        wdat  = mem_dq_out;
        wlen++;
      end else if (wlen > 0) begin
        chk(wlen == WR_E, "R3 write pulse length", wlen, WR_E);
        chk(mem_dq_oe, "R4 driver held after strobe", mem_dq_oe, 1);
        mem[waddr] = wdat;
        wlen  = 0;
        whold = 1;
      end
    end
  end

  // called at a negedge; returns at the negedge where ready is back
  task automatic do_req(input bit w, input int a, input logic [7:0] d);
    int k;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = ADDR_W'(a);
    req_wdata = d;
    k = 0;
    while (!req_ready && k < 100) begin @(negedge clk); k++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 ready low after accept", req_ready, 0);
    k = 0;
    if (!w) begin
      while (!rsp_valid && k < 100) begin @(negedge clk); k++; end
      chk(k == RD_E, "R2 response latency", k, RD_E);
      chk(rsp_rdata == d, "R7 read data", rsp_rdata, d);
      while (!req_ready && k < 100) begin
        @(negedge clk); k++;
        if (rsp_valid) chk(0, "R2 response longer than one cycle", k, RD_E);
      end
      chk(k == RD_E + TA_E, "R5 R6 read busy incl. turnaround", k, RD_E + TA_E);
    end else begin
      while (!req_ready && k < 100) begin @(negedge clk); k++; end
      chk(k == WR_E + 1, "R6 write busy", k, WR_E + 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rsp_valid, "R1 driver off in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // fill every address, then read all back
    for (int a = 0; a < DEPTH; a++) do_req(1'b1, a, pat(a));
    repeat (5) begin
      @(negedge clk);
      chk(mem_cs_n && !mem_dq_oe && mem_oe_n && mem_we_n, "R1 idle deselect", mem_cs_n, 1);
    end
    for (int a = 0; a < DEPTH; a++) do_req(1'b0, a, pat(a));

    // read then write back to back, then verify (R7, R5)
    for (int a = 0; a < 96; a++) begin
      do_req(1'b0, a * 7 % DEPTH, pat(a * 7 % DEPTH));
      do_req(1'b1, a * 7 % DEPTH, ~pat(a * 7 % DEPTH));
      do_req(1'b0, a * 7 % DEPTH, ~pat(a * 7 % DEPTH));
    end
    // untouched neighbours unchanged
    for (int a = 1; a < 64; a += 7) do_req(1'b0, a, pat(a));
    chk(mem_cs_n && !rsp_valid, "R1 idle at end", mem_cs_n, 1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule